// File: doc/BRIEF.md
# Five-Level Switched-Capacitor Inverter Modulator

This block generates the gate commands for a single-phase five-level inverter built from a switched-capacitor ladder followed by a polarity bridge. A signed reference sample is reduced to a sign and a magnitude. The magnitude is compared against a stack of level-shifted triangular carriers that share one phase and one period. The lowest bands drive the three level switches. The highest band drives the pair of complementary clamping groups that put the ladder capacitors in parallel.

The capacitors stay balanced only when the clamping groups change state regularly. To ensure this, the block swaps which group follows the highest band at every carrier valley. In one period group B follows the highest band, and in the next period group A does. At a low modulation index the highest band never fires, so the swap alone makes both groups toggle once per period. The reference and the period setting are taken at the valley only, so the gate pattern never changes its rules in the middle of a period.

Top module: `mcpwm_balance`

## Requirements
- R1: After reset, gate_grp_a is 1, gate_grp_b is 0, gate_lvl is all zero, gate_pol is 1 and combo_sel is 0, with a held carrier limit of 1 and a held reference of 0.
- R2: The carrier counts 0,1,…,L,…,1 and then back to 0, so one period lasts 2·L clock cycles. L is the period input taken at each valley, and a setting of 0 is used as 1.
- R3: Band k (k = 0 is the lowest) is on while the held magnitude is greater than k·L plus the carrier value. gate_lvl[i] carries band i for every band below the highest, so gate_lvl[2], [1] and [0] are S1, S2 and S3 for four bands.
- R4: gate_pol is 1 when the held reference is zero or positive and 0 when it is negative. The magnitude of the most negative code saturates to 2^(REF_W-1)-1.
- R5: gate_grp_a and gate_grp_b are never equal.
- R6: While combo_sel is 0, gate_grp_b equals the highest band. While combo_sel is 1, gate_grp_a equals the highest band.
- R7: combo_sel inverts at every valley, that is, on the clock edge where the falling carrier reaches 0. With a zero reference, each group therefore toggles once per period.
- R8: ref_in and per_lim are taken only on the valley edge. Values applied at any other cycle have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | REF_W | Signed reference sample |
| per_lim | input | CNT_W | Carrier peak value L (half-period in cycles) |
| gate_grp_a | output | 1 | Clamping group A gate |
| gate_grp_b | output | 1 | Clamping group B gate |
| gate_lvl | output | NUM_BANDS-1 | Level switch gates, bit i is band i |
| gate_pol | output | 1 | Polarity bridge gate, 1 for positive output |
| combo_sel | output | 1 | Active working-state combination |

## Verification
Constant references are swept in steps across the full signed range at several period settings, including 0 and 1. These sweeps separate errors in the band thresholds, in the sign handling and in the period from each other. A zero reference shows that the group swap alone makes both groups toggle. The most negative code exposes an abs overflow. A final phase changes the reference on every cycle and the period on every few cycles. Any output that reacts away from the valley edge is reported against a bench model that latches its inputs only at valleys.

// File: rtl/mcpwm_pkg.sv
package mcpwm_pkg;
   typedef enum logic {
      DIR_UP   = 1'b0,
      DIR_DOWN = 1'b1
   } car_dir_e;

   typedef enum logic {
      COMBO_B_TOP = 1'b0,
      COMBO_A_TOP = 1'b1
   } combo_e;
endpackage

// File: rtl/mcpwm_carrier.sv
module mcpwm_carrier #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] lim_in,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] lim_o,
   output logic             valley_o
);
   import mcpwm_pkg::*;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] lim_q;
   logic [CNT_W-1:0] lim_fix;
   logic [CNT_W:0]   cnt_inc;
   car_dir_e         dir_q;

   assign lim_fix  = (lim_in == '0) ? CNT_W'(1) : lim_in;
   assign cnt_inc  = {1'b0, cnt_q} + (CNT_W+1)'(1);
   assign valley_o = (dir_q == DIR_DOWN) && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lim_q <= CNT_W'(1);
         dir_q <= DIR_UP;
      end else if (dir_q == DIR_UP) begin
         cnt_q <= cnt_inc[CNT_W-1:0];
         if (cnt_inc >= {1'b0, lim_q}) begin
            dir_q <= DIR_DOWN;
         end
      end else begin
         cnt_q <= cnt_q - CNT_W'(1);
         if (valley_o) begin
            dir_q <= DIR_UP;
            lim_q <= lim_fix;
         end
      end
   end

   assign cnt_o = cnt_q;
   assign lim_o = lim_q;
endmodule

// File: rtl/mcpwm_refcap.sv
module mcpwm_refcap #(
   parameter int REF_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [REF_W-1:0] ref_in,
   output logic [REF_W-2:0] mag_o,
   output logic             neg_o
);
   logic [REF_W-1:0] ref_q;
   logic [REF_W-1:0] abs_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_q <= '0;
      end else if (load) begin
         ref_q <= ref_in;
      end
   end

   assign neg_o = ref_q[REF_W-1];
   assign abs_v = neg_o ? (~ref_q + REF_W'(1)) : ref_q;
   assign mag_o = abs_v[REF_W-1] ? '1 : abs_v[REF_W-2:0];
endmodule

// File: rtl/mcpwm_bands.sv
module mcpwm_bands #(
   parameter int CNT_W = 8,
   parameter int MAG_W = 11,
   parameter int NB    = 4
) (
   input  logic [MAG_W-1:0] mag,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] lim,
   output logic [NB-1:0]    band_o
);
   localparam int KW    = $clog2(NB) + 1;
   localparam int TH_W  = CNT_W + KW;
   localparam int CMP_W = ((MAG_W > TH_W) ? MAG_W : TH_W) + 1;

   for (genvar k = 0; k < NB; k++) begin : g_band
      logic [TH_W-1:0] th;
      assign th        = TH_W'(k) * TH_W'(lim) + TH_W'(cnt);
      assign band_o[k] = CMP_W'(mag) > CMP_W'(th);
   end
endmodule

// File: rtl/mcpwm_balsel.sv
module mcpwm_balsel (
   input  logic clk,
   input  logic rst_n,
   input  logic valley,
   input  logic band_top,
   output logic combo_o,
   output logic grp_a_o,
   output logic grp_b_o
);
   import mcpwm_pkg::*;

   combo_e combo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         combo_q <= COMBO_B_TOP;
      end else if (valley) begin
         combo_q <= (combo_q == COMBO_B_TOP) ? COMBO_A_TOP : COMBO_B_TOP;
      end
   end

   assign combo_o = (combo_q == COMBO_A_TOP);
   assign grp_b_o = (combo_q == COMBO_B_TOP) ? band_top : ~band_top;
   assign grp_a_o = ~grp_b_o;
endmodule

// File: rtl/mcpwm_balance.sv
module mcpwm_balance #(
   parameter int CNT_W     = 8,
   parameter int REF_W     = 12,
   parameter int NUM_BANDS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [REF_W-1:0]     ref_in,
   input  logic [CNT_W-1:0]     per_lim,
   output logic                 gate_grp_a,
   output logic                 gate_grp_b,
   output logic [NUM_BANDS-2:0] gate_lvl,
   output logic                 gate_pol,
   output logic                 combo_sel
);
   localparam int MAG_W = REF_W - 1;

   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end
   if (REF_W < 3) begin : g_bad_ref
      $error("REF_W must be at least 3");
   end
   if (NUM_BANDS < 2) begin : g_bad_nb
      $error("NUM_BANDS must be at least 2");
   end

   logic [CNT_W-1:0]     cnt;
   logic [CNT_W-1:0]     lim;
   logic                 valley;
   logic [MAG_W-1:0]     mag;
   logic                 neg;
   logic [NUM_BANDS-1:0] band;

   mcpwm_carrier #(.CNT_W(CNT_W)) u_carrier (
      .clk      (clk),
      .rst_n    (rst_n),
      .lim_in   (per_lim),
      .cnt_o    (cnt),
      .lim_o    (lim),
      .valley_o (valley)
   );

   mcpwm_refcap #(.REF_W(REF_W)) u_refcap (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (valley),
      .ref_in (ref_in),
      .mag_o  (mag),
      .neg_o  (neg)
   );

   mcpwm_bands #(.CNT_W(CNT_W), .MAG_W(MAG_W), .NB(NUM_BANDS)) u_bands (
      .mag    (mag),
      .cnt    (cnt),
      .lim    (lim),
      .band_o (band)
   );

   mcpwm_balsel u_balsel (
      .clk      (clk),
      .rst_n    (rst_n),
      .valley   (valley),
      .band_top (band[NUM_BANDS-1]),
      .combo_o  (combo_sel),
      .grp_a_o  (gate_grp_a),
      .grp_b_o  (gate_grp_b)
   );

   assign gate_lvl = band[NUM_BANDS-2:0];
   assign gate_pol = ~neg;
endmodule

// File: rtl/mcpwm_balance_chk.sv
module mcpwm_balance_chk #(
   parameter int CNT_W     = 8,
   parameter int NUM_BANDS = 4
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 gate_grp_a,
   input logic                 gate_grp_b,
   input logic [NUM_BANDS-2:0] gate_lvl,
   input logic                 gate_pol,
   input logic                 combo_sel
);
   localparam int unsigned LIM_MAX = (2 ** CNT_W) - 1;

   logic             prev_combo_q;
   logic [CNT_W+1:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_combo_q <= 1'b0;
         since_q      <= '0;
      end else begin
         prev_combo_q <= combo_sel;
         if (combo_sel != prev_combo_q) begin
            since_q <= '0;
         end else if (since_q != '1) begin
            since_q <= since_q + 1'b1;
         end
      end
   end

   // R5
   grp_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      gate_grp_a != gate_grp_b);

   // R2
   period_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      32'(since_q) <= 2 * LIM_MAX);

   // R8
   pol_at_valley_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gate_pol) |-> !$stable(combo_sel));

   // R3
   lvl_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((gate_lvl >> 1) & ~gate_lvl) == '0);

   // R6
   b_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!combo_sel && gate_grp_b) |-> gate_lvl[NUM_BANDS-2]);

   // R6
   a_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (combo_sel && gate_grp_a) |-> gate_lvl[NUM_BANDS-2]);
endmodule

bind mcpwm_balance mcpwm_balance_chk #(
   .CNT_W     (CNT_W),
   .NUM_BANDS (NUM_BANDS)
) u_chk (.*);

// File: tb/mcpwm_balance_bench.sv
`timescale 1ns/1ps
module mcpwm_balance_bench;
   localparam int CW = 4;
   localparam int RW = 8;
   localparam int NB = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [RW-1:0] ref_in = '0;
   logic [CW-1:0] per_lim = '0;
   logic          gate_grp_a, gate_grp_b, gate_pol, combo_sel;
   logic [NB-2:0] gate_lvl;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // bench model state, updated from the requirements
   int m_cnt, m_lim, m_ref;
   bit m_up, m_combo;

   always #10 clk = ~clk;

   mcpwm_balance #(.CNT_W(CW), .REF_W(RW), .NUM_BANDS(NB)) u_mcpwm_balance (
      .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .per_lim(per_lim),
      .gate_grp_a(gate_grp_a), .gate_grp_b(gate_grp_b), .gate_lvl(gate_lvl),
      .gate_pol(gate_pol), .combo_sel(combo_sel)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   function automatic int mag_of(input int r);
      if (r == -128) return 127;
      return (r < 0) ? -r : r;
   endfunction

   task automatic check_all();
      int mg;
      int bands;
      bit top, exp_b;
      mg = mag_of(m_ref);
      bands = 0;
      for (int k = 0; k < NB; k++)
         if (mg > k * m_lim + m_cnt) bands |= (1 << k);
      top   = bands[NB-1];
      exp_b = m_combo ? !top : top;
      // R3 level bands
      chk(int'(gate_lvl) == (bands & ((1 << (NB-1)) - 1)), "R3", int'(gate_lvl),
          bands & ((1 << (NB-1)) - 1));
      // R4 polarity
      chk(gate_pol == (m_ref >= 0), "R4", gate_pol, m_ref >= 0);
      // R5 complementary groups
      chk(gate_grp_a != gate_grp_b, "R5", gate_grp_a, !gate_grp_b);
      // R6 top band mapping
      chk(gate_grp_b == exp_b, "R6", gate_grp_b, exp_b);
      // R7 and R2 combination flag, period timing
      chk(combo_sel == m_combo, "R7", combo_sel, m_combo);
   endtask

   task automatic model_adv(input int r, input int l);
      if (m_up) begin
         m_cnt++;
         if (m_cnt >= m_lim) m_up = 0;
      end else begin
         if (m_cnt == 1) begin
            // R8 inputs taken at the valley only
            m_up    = 1;
            m_combo = !m_combo;
            m_ref   = r;
            m_lim   = (l == 0) ? 1 : l;
         end
         m_cnt--;
      end
   endtask

   task automatic step(input int r, input int l);
      check_all();
      ref_in  = RW'(r);
      per_lim = CW'(l);
      model_adv(r, l);
      @(negedge clk);
   endtask

   initial begin
      int lims[4];
      lims = '{0, 1, 3, 6};
      m_cnt = 0; m_lim = 1; m_ref = 0; m_up = 1; m_combo = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(gate_grp_a == 1'b1, "R1", gate_grp_a, 1);
      chk(gate_grp_b == 1'b0, "R1", gate_grp_b, 0);
      chk(gate_lvl == '0, "R1", int'(gate_lvl), 0);
      chk(gate_pol == 1'b1, "R1", gate_pol, 1);
      chk(combo_sel == 1'b0, "R1", combo_sel, 0);
      // R2 R3 R4 sweep of constant references at several periods
      foreach (lims[i]) begin
         for (int r = -30; r <= 30; r += 3) begin
            int len;
            len = 4 * ((lims[i] == 0) ? 1 : lims[i]) + 4;
            for (int c = 0; c < len; c++) step(r, lims[i]);
         end
         for (int c = 0; c < 40; c++) step(-128, lims[i]);
         for (int c = 0; c < 40; c++) step(127, lims[i]);
      end
      // R7 zero reference: both groups toggle every period
      for (int c = 0; c < 60; c++) step(0, 5);
      // R8 inputs changing every cycle
      for (int c = 0; c < 400; c++) step(((c * 37) % 101) - 50, (c / 7) % 8);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule